// File: doc/BRIEF.md
# Tick-Driven Limit Timer Channel

This block is one counter/timer channel, controlled through a 32-bit register port. A counter moves forward by one step on every cycle in which the tick enable input is high. In the intended system that input pulses once per 500 ns. The count is kept in a bit field of the counter word, and each step adds 0x200 to that word in the default layout. On each step the count is compared against a programmable limit. When a tick arrives while the count equals the limit, the counter returns to zero, the reached flag in bit 31 is set and the interrupt output goes high. A stored limit of zero makes the counter free-run to the largest value the field can hold.

Software acknowledges an event by reading the limit register, which clears both the reached flag and the interrupt. The limit can be written at two addresses. One restarts the count and the other leaves the running count alone. The register word is selected by address bits 4..2.

Top module: `tick_limit_timer`

## Requirements
- R1: After a synchronous reset the stored limit, the count and the reached flag are zero and `irq` is low. Reads of index 0 and index 1 then return 0, and the counter advances on the next tick with no programming.
- R2: With each cycle in which `tick_en` is high, the count field (bits CNT_MSB..CNT_LSB, default 30..9) grows by one. Without a tick it holds. Bits below CNT_LSB and between CNT_MSB and bit 31 read as zero.
- R3: A tick that arrives while the count equals a nonzero limit field returns the count to zero. In that same clock edge it sets the reached flag and raises `irq`.
- R4: A write to index 0 stores `wdata` masked to the count field (0x7ffffe00 by default), returns the count to zero and drops `irq`. It leaves the reached flag as it was.
- R5: A write to index 2 stores the limit with the same mask and leaves the count untouched. Later events use the new limit.
- R6: With a stored limit of zero, the count runs to the all-ones field value. The next tick wraps it to zero and raises the event as in R3.
- R7: A read of index 0 returns the stored limit and clears the reached flag and `irq`. If an event happens in the same cycle, the event wins and both stay set.
- R8: A read of index 1 returns the count field with the reached flag in bit 31. The read has no side effect on any state.
- R9: Writes to index 1 and to indices 3 to 7 change nothing. Reads of indices 2 to 7 return zero. Address bits 1..0 are ignored.
- R10: A write to index 0 in the same cycle as a tick that would hit the limit restarts the count. No event is raised.
- R11: `rdata` is loaded at the clock edge that samples `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable (500 ns period in the target system) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (5) | Byte address; bits 4..2 select the word |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Interrupt, high from an event until acknowledged or limit rewrite |

## Verification
The hardest cases are the collisions at the terminal count. One is an acknowledge read that lands on the same edge as the event. The other is a restarting limit write on that edge. Both need the bench to know exactly which tick reaches the limit, so the stimulus uses a limit of one and places the read or write in the very cycle that carries the second tick. The free-run wrap would take millions of ticks at the default width. The bench therefore builds the channel with a seven-bit count field, so a limit of zero wraps after 128 ticks.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_LIMIT      = 3'd0;
  localparam logic [IDX_W-1:0] IDX_COUNT      = 3'd1;
  localparam logic [IDX_W-1:0] IDX_LIMIT_KEEP = 3'd2;

  typedef struct packed {
    logic wr_lim;   // write limit, restart count
    logic wr_keep;  // write limit, count keeps running
    logic rd_lim;   // read limit, acknowledge
    logic rd_cnt;   // read count word
  } strobe_t;
endpackage

// File: rtl/ltmr_decode.sv
module ltmr_decode
  import ltmr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  idx
);
  assign idx = addr[IDX_W+1:2];

  always_comb begin
    strb         = '0;
    strb.wr_lim  = wr_en && (idx == IDX_LIMIT);
    strb.wr_keep = wr_en && (idx == IDX_LIMIT_KEEP);
    strb.rd_lim  = rd_en && (idx == IDX_LIMIT);
    strb.rd_cnt  = rd_en && (idx == IDX_COUNT);
  end
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  output logic [CNT_W-1:0] limit_o,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] end_val;

  assign end_val = (limit_o == '0) ? CNT_MAX : limit_o;
  assign hit_o   = tick_i && !restart_i && (count_o == end_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_o <= '0;
    end else if (lim_we_i) begin
      limit_o <= lim_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (restart_i || hit_o) begin
      count_o <= '0;
    end else if (tick_i) begin
      count_o <= count_o + 1'b1;
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(count_o));
  // R3
  hit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> (count_o == '0));
  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (count_o == '0));
endmodule

// File: rtl/ltmr_flags.sv
module ltmr_flags (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic wr_lim_i,
  input  logic rd_lim_i,
  output logic reached_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reached_o <= 1'b0;
    end else if (hit_i) begin
      reached_o <= 1'b1;
    end else if (rd_lim_i) begin
      reached_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else if (wr_lim_i) begin
      irq_o <= 1'b0;
    end else if (hit_i) begin
      irq_o <= 1'b1;
    end else if (rd_lim_i) begin
      irq_o <= 1'b0;
    end
  end

  // R3
  hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (reached_o && irq_o));
  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lim_i |=> !irq_o);
  // R7
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> reached_o);
endmodule

// File: rtl/tick_limit_timer.sv
module tick_limit_timer
  import ltmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int CNT_LSB = 9,
  parameter int CNT_MSB = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W    = CNT_MSB - CNT_LSB + 1;
  localparam int FLAG_BIT = DATA_W - 1;

  strobe_t          strb;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_q;
  logic             hit;
  logic             reached;
  logic [DATA_W-1:0] lim_word;
  logic [DATA_W-1:0] cnt_word;
  logic [DATA_W-1:0] rd_next;
  logic             unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:CNT_MSB+1], wdata[CNT_LSB-1:0], addr};

  ltmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .strb  (strb),
    .idx   (idx)
  );

  ltmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_en),
    .restart_i   (strb.wr_lim),
    .lim_we_i    (strb.wr_lim || strb.wr_keep),
    .lim_wdata_i (wdata[CNT_MSB:CNT_LSB]),
    .limit_o     (limit_q),
    .count_o     (count_q),
    .hit_o       (hit)
  );

  ltmr_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit),
    .wr_lim_i  (strb.wr_lim),
    .rd_lim_i  (strb.rd_lim),
    .reached_o (reached),
    .irq_o     (irq)
  );

  always_comb begin
    lim_word                  = '0;
    lim_word[CNT_MSB:CNT_LSB] = limit_q;
    cnt_word                  = '0;
    cnt_word[CNT_MSB:CNT_LSB] = count_q;
    cnt_word[FLAG_BIT]        = reached;
    if (strb.rd_lim) begin
      rd_next = lim_word;
    end else if (strb.rd_cnt) begin
      rd_next = cnt_word;
    end else begin
      rd_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end

  // R9
  rd_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[IDX_W+1:2] > IDX_COUNT)) |=> (rdata == '0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_tick_limit_timer.sv
module tb_tick_limit_timer;
  localparam int CNT_LSB = 9;
  localparam int CNT_MSB = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tick_limit_timer #(.DATA_W(32), .ADDR_W(5), .CNT_LSB(CNT_LSB), .CNT_MSB(CNT_MSB)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops one expected item for every read the design captured
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read without expectation, actual %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic step(input logic tk, input logic wr, input logic rd,
                      input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    tick_en = tk; wr_en = wr; rd_en = rd;
    addr = {idx, 2'b11}; wdata = d;
    @(posedge clk);
    #1;
    tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    step(1'b0, 1'b1, 1'b0, idx, d);
  endtask

  task automatic rd(input logic [2:0] idx, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    step(1'b0, 1'b0, 1'b1, idx, 32'h0);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(3'd0, 32'h0, "R1 limit after reset");
    rd(3'd1, 32'h0, "R1 count after reset");
    chk_irq(1'b0, "R1 irq after reset");
    // R2 counting and hold
    ticks(5);
    rd(3'd1, 32'h0000_0A00, "R2 five ticks");
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    rd(3'd1, 32'h0000_0A00, "R2 hold without tick");
    rd(3'd1, 32'h0000_0A00, "R11 repeat read");
    // R4 restarting limit write
    wr(3'd0, 32'hFFFF_0600);
    rd(3'd0, 32'h0000_0600, "R4 masked limit");
    rd(3'd1, 32'h0, "R4 count restarted");
    // R3 terminal count
    ticks(3);
    rd(3'd1, 32'h0000_0600, "R3 count at limit");
    chk_irq(1'b0, "R3 no irq before terminal tick");
    ticks(1);
    chk_irq(1'b1, "R3 irq on terminal tick");
    rd(3'd1, 32'h8000_0000, "R3 wrapped with flag");
    chk_irq(1'b1, "R8 count read leaves irq");
    rd(3'd0, 32'h0000_0600, "R7 ack read value");
    chk_irq(1'b0, "R7 ack drops irq");
    rd(3'd1, 32'h0, "R7 ack clears flag");
    // R5 limit write without restart
    ticks(2);
    wr(3'd2, 32'hFFFF_0A00);
    rd(3'd1, 32'h0000_0400, "R5 count kept");
    ticks(3);
    chk_irq(1'b0, "R5 no irq before new limit");
    ticks(1);
    chk_irq(1'b1, "R5 irq at new limit");
    // R4 write drops irq, flag kept
    wr(3'd0, 32'h0000_0A00);
    chk_irq(1'b0, "R4 write drops irq");
    rd(3'd1, 32'h8000_0000, "R4 flag kept after write");
    rd(3'd0, 32'h0000_0A00, "R7 ack");
    // R9 ignored writes and zero reads
    ticks(2);
    wr(3'd1, 32'h0000_7E00);
    for (int i = 3; i < 8; i++) wr(3'(i), 32'hFFFF_FFFF);
    rd(3'd0, 32'h0000_0A00, "R9 limit untouched");
    rd(3'd1, 32'h0000_0400, "R9 count untouched");
    chk_irq(1'b0, "R9 irq untouched");
    for (int i = 2; i < 8; i++) rd(3'(i), 32'h0, "R9 unused index reads zero");
    // R6 free run with zero limit
    wr(3'd0, 32'h0);
    ticks(127);
    rd(3'd1, 32'h0000_FE00, "R6 count at field max");
    chk_irq(1'b0, "R6 no irq before wrap");
    ticks(1);
    chk_irq(1'b1, "R6 irq at wrap");
    rd(3'd1, 32'h8000_0000, "R6 wrapped with flag");
    rd(3'd0, 32'h0, "R6 ack zero limit");
    // R7 event wins over coincident ack
    wr(3'd0, 32'h0000_0200);
    ticks(1);
    exp_q.push_back(32'h0000_0200);
    tag_q.push_back("R7 ack read during event");
    step(1'b1, 1'b0, 1'b1, 3'd0, 32'h0);
    chk_irq(1'b1, "R7 event wins over ack");
    rd(3'd1, 32'h8000_0000, "R7 flag survives coincident ack");
    rd(3'd0, 32'h0000_0200, "R7 ack");
    // R10 restart wins over coincident terminal tick
    ticks(1);
    step(1'b1, 1'b1, 1'b0, 3'd0, 32'h0000_0200);
    chk_irq(1'b0, "R10 no irq on restart");
    rd(3'd1, 32'h0, "R10 count zero no flag");
    ticks(1);
    rd(3'd1, 32'h0000_0200, "R10 counts after restart");
    // R1 reset mid-run
    do_reset();
    rd(3'd0, 32'h0, "R1 limit after second reset");
    rd(3'd1, 32'h0, "R1 count after second reset");
    chk_irq(1'b0, "R1 irq after second reset");
    ticks(1);
    rd(3'd1, 32'h0000_0200, "R1 free-runs after reset");
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule